// File: doc/BRIEF.md
# Fractional M/N:D Clock Divider

This block derives a slower clock, expressed as a per-cycle level on a single reference clock, from one of up to eight input sources. Each source is modelled as an enable (tick) on the reference clock. A selected source first passes through a small integer pre-divider. The divided ticks then drive an accumulator that adds M on every tick, modulo N. The output level is set by comparing the accumulator with a duty value D, or with M in the single-edge modes. The result is a fractional M/N rate with a programmable high time.

Two 32-bit control words configure the divider. The MD word carries M and the complement of D. The NS word carries:
- the complement of N-M;
- the counter mode;
- the pre-divider value minus one;
- the source select;
- a counter-hold bit;
- separate root and branch enables.

Software holds the counter, writes the MD word and then releases the hold. It enables the root before the branch. New M, N, D and mode values are captured only at a period boundary, so a partially programmed period never reaches the output.

Top module: `mnd_clk_div`

## Requirements
- R1: After a synchronous active-low reset, `div_out` and `running` are both 0.
- R2: M is MD[23:16], D is the complement of MD[7:0], and N is (complement of NS[23:16]) + M, modulo 256. In dual-edge mode (NS[6:5] = 2), the accumulator starts at 0 and adds M on each divided tick, modulo N. `div_out` is high while the accumulator is below D. With M=1, N=4, D=2 and one divided tick per cycle, the output reads 1,1,0,0 repeating.
- R3: With M > 1 the rate is fractional. For M=3, N=8, D=4 the output reads 1,1,0,1,0,0,1,0.
- R4: In modes 1 and 3 (single-edge), `div_out` is high while the accumulator is below M. For M=1 and N=4 the output reads 1,0,0,0.
- R5: Mode 0, or N = 0 in any mode, is bypass. `div_out` is high for one cycle after each divided tick, and the accumulator does not advance.
- R6: NS[4:3] holds the pre-divider value minus one. A field value of 3 yields one divided tick per four source ticks.
- R7: NS[2:0] selects which `src_en` bit is counted. Ticks on the other sources are ignored.
- R8: While NS[7] is 1, `div_out` is 0 in that same cycle. On release, the sequence restarts from accumulator 0.
- R9: Clearing NS[11] forces `div_out` and `running` to 0 after the next clock edge.
- R10: `running` rises one edge after NS[9] is seen together with an already-active root. Writing NS[11] and NS[9] together makes it rise on the second edge. `running` never rises without the root, and `div_out` is 0 whenever `running` is 0.
- R11: A change to M, N, D or the mode takes effect at the next period boundary (accumulator wrap), never in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_en | input | NUM_SRC | Per-source tick enables |
| md_word | input | 32 | M and complemented-D control word |
| ns_word | input | 32 | N-M, mode, pre-divider, select, hold and enable control word |
| div_out | output | 1 | Divided clock level, gated by the branch |
| running | output | 1 | Branch output is active |

## Verification
`div_out` is a combinational function of registered state and the live hold bit. A hold therefore shows within the same cycle, while accumulator steps, pre-divider steps and shadow loads show one edge later. The root enable takes one edge to act and `running` takes two. The bench drives every input on the falling edge and samples 2 ns later, so each recorded sample reflects exactly the edges that have already passed. Output sequences are compared as whole bit strings of known length, which makes a one-cycle slip show up as a mismatch.

// File: rtl/mnd_pkg.sv
// Shared definitions for the M/N:D divider: control-word field positions
// and the counter-mode encoding. Assumes 32-bit MD and NS words.
package mnd_pkg;
    localparam int CW       = 8;   // counter and N-M field width
    localparam int PW       = 2;   // pre-divider field width
    localparam int SEL_W    = 3;   // source select width
    localparam int NS_NM_LO = 16;
    localparam int NS_MODE  = 5;
    localparam int NS_PRE   = 3;
    localparam int NS_SEL   = 0;
    localparam int NS_HOLD  = 7;
    localparam int NS_BRANCH = 9;
    localparam int NS_ROOT  = 11;
    localparam int MD_M_LO  = 16;
    localparam int MD_D_LO  = 0;

    typedef enum logic [1:0] {
        MODE_BYPASS  = 2'd0,
        MODE_SINGLE  = 2'd1,
        MODE_DUAL    = 2'd2,
        MODE_SINGLE2 = 2'd3
    } cnt_mode_e;
endpackage

// File: rtl/mnd_en_seq.sv
// Root/branch enable sequencing. The root takes effect one edge after
// its request. The branch only turns on once the root has already been
// on for a cycle. Assumes requests are static register bits.
module mnd_en_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic root_req,
    input  logic branch_req,
    input  logic hold_req,
    output logic active,
    output logic branch_on
);
    logic root_q;

    // Register root and branch state, with the branch gated by the prior root.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_q    <= 1'b0;
            branch_on <= 1'b0;
        end else begin
            root_q    <= root_req;
            branch_on <= branch_req & root_req & root_q;
        end
    end

    // Counter runs only with the root on and no hold request.
    always_comb active = root_q & ~hold_req;
endmodule

// File: rtl/mnd_prediv.sv
// Source selection and integer pre-divider. Emits one pre_tick per
// (pdiv+1) ticks of the selected source. Assumes NUM_SRC <= 2**SEL_W;
// unimplemented selects never tick.
module mnd_prediv #(
    parameter int NUM_SRC = 8,
    parameter int SEL_W   = 3,
    parameter int PW      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               active,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [SEL_W-1:0]   sel,
    input  logic [PW-1:0]      pdiv,
    output logic               pre_tick
);
    localparam int NPAD = 1 << SEL_W;

    logic [NPAD-1:0] src_pad;
    logic [PW-1:0]   pre_cnt;
    logic            tick;

    generate
        if (NUM_SRC < NPAD) begin : g_pad
            assign src_pad = {{(NPAD-NUM_SRC){1'b0}}, src_en};
        end else begin : g_full
            assign src_pad = src_en[NPAD-1:0];
        end
    endgenerate

    // Pick the selected source and detect the terminal pre-divider count.
    always_comb begin
        tick     = src_pad[sel];
        pre_tick = active & tick & (pre_cnt == pdiv);
    end

    // Count selected ticks, restarting from zero while inactive.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)
            pre_cnt <= '0;
        else if (pre_tick)
            pre_cnt <= '0;
        else if (tick)
            pre_cnt <= pre_cnt + 1'b1;
    end
endmodule

// File: rtl/mnd_mn_counter.sv
// M/N accumulator with duty compare and shadowed configuration.
// Settings are captured while inactive or at a period boundary (wrap, or
// every tick in bypass). Assumes pre_tick is only high while active.
module mnd_mn_counter
    import mnd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active,
    input  logic         pre_tick,
    input  logic [W-1:0] m_in,
    input  logic [W-1:0] nm_inv_in,
    input  logic [W-1:0] d_inv_in,
    input  logic [1:0]   mode_in,
    output logic         out_raw,
    output logic [W-1:0] duty_cur,
    output logic         shadow_load
);
    logic [W-1:0] m_sh, n_sh, d_sh, acc;
    cnt_mode_e    mode_sh;
    logic         pre_q;
    logic [W:0]   sum, diff;
    logic         wrap, bypass, boundary;

    // Next accumulator value and period-boundary detection.
    always_comb begin
        sum      = {1'b0, acc} + {1'b0, m_sh};
        diff     = sum - {1'b0, n_sh};
        wrap     = (sum >= {1'b0, n_sh});
        bypass   = (mode_sh == MODE_BYPASS) || (n_sh == '0);
        boundary = pre_tick & (bypass | wrap);
        shadow_load = ~active | boundary;
    end

    // Advance the accumulator by M per divided tick, modulo N.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            acc   <= '0;
            pre_q <= 1'b0;
        end else begin
            pre_q <= pre_tick;
            if (pre_tick && !bypass)
                acc <= wrap ? diff[W-1:0] : sum[W-1:0];
        end
    end

    // Capture M, N, D and mode only at safe points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_sh    <= '0;
            n_sh    <= '0;
            d_sh    <= '0;
            mode_sh <= MODE_BYPASS;
        end else if (shadow_load) begin
            m_sh    <= m_in;
            n_sh    <= ~nm_inv_in + m_in;
            d_sh    <= ~d_inv_in;
            mode_sh <= cnt_mode_e'(mode_in);
        end
    end

    // Output level per counter mode.
    always_comb begin
        case (mode_sh)
            MODE_DUAL:   out_raw = bypass ? pre_q : (acc < d_sh);
            MODE_BYPASS: out_raw = pre_q;
            default:     out_raw = bypass ? pre_q : (acc < m_sh);
        endcase
        duty_cur = d_sh;
    end
endmodule

// File: rtl/mnd_clk_div.sv
// Top of the M/N:D divider. Decodes the MD and NS control words, runs
// the enable sequencer, pre-divider and M/N counter, and gates the
// result with the branch enable. Sources are tick enables on clk.
module mnd_clk_div
    import mnd_pkg::*;
#(
    parameter int NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [31:0]        md_word,
    input  logic [31:0]        ns_word,
    output logic               div_out,
    output logic               running
);
    logic          active, branch_on, pre_tick, out_raw, shadow_load;
    logic [CW-1:0] duty_cur;
    logic          unused_bits;

    assign unused_bits = ^{md_word[31:24], md_word[15:8],
                           ns_word[31:24], ns_word[15:12], ns_word[10], ns_word[8]};

    mnd_en_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .root_req   (ns_word[NS_ROOT]),
        .branch_req (ns_word[NS_BRANCH]),
        .hold_req   (ns_word[NS_HOLD]),
        .active     (active),
        .branch_on  (branch_on)
    );

    mnd_prediv #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .PW(PW)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .src_en   (src_en),
        .sel      (ns_word[NS_SEL +: SEL_W]),
        .pdiv     (ns_word[NS_PRE +: PW]),
        .pre_tick (pre_tick)
    );

    mnd_mn_counter #(.W(CW)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .pre_tick    (pre_tick),
        .m_in        (md_word[MD_M_LO +: CW]),
        .nm_inv_in   (ns_word[NS_NM_LO +: CW]),
        .d_inv_in    (md_word[MD_D_LO +: CW]),
        .mode_in     (ns_word[NS_MODE +: 2]),
        .out_raw     (out_raw),
        .duty_cur    (duty_cur),
        .shadow_load (shadow_load)
    );

    // Gate the divided level with the branch and the live counter state.
    always_comb begin
        div_out = branch_on & active & out_raw;
        running = branch_on;
    end
endmodule

// File: rtl/mnd_clk_div_chk.sv
// Property checker for mnd_clk_div, attached by bind. Observes the
// ports plus the counter's duty shadow and its load strobe.
module mnd_clk_div_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] ns_word,
    input logic        div_out,
    input logic        running,
    input logic        active,
    input logic        shadow_load,
    input logic [7:0]  duty_cur
);
    a_r8_hold_forces_low: assert property (@(posedge clk) disable iff (!rst_n)
        ns_word[7] |-> !div_out);

    a_r9_root_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!ns_word[11]) |-> !div_out);

    a_r10_branch_after_root: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> $past(ns_word[11], 2));

    a_r10_out_needs_branch: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !div_out);

    a_r11_duty_held: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !shadow_load) |=> $stable(duty_cur));
endmodule

bind mnd_clk_div mnd_clk_div_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ns_word     (ns_word),
    .div_out     (div_out),
    .running     (running),
    .active      (active),
    .shadow_load (shadow_load),
    .duty_cur    (duty_cur)
);

// File: tb/mnd_clk_div_tb.sv
module mnd_clk_div_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_en = 8'hFF;
    logic [31:0] md_r = '0;
    logic [31:0] ns_r = '0;
    logic        div_out, running;
    int          checks = 0;
    int          fails = 0;

    localparam logic [31:0] HOLD = 32'h80;
    localparam logic [31:0] BR   = 32'h200;
    localparam logic [31:0] ROOT = 32'h800;

    always #10 clk = ~clk;

    mnd_clk_div u_dut (
        .clk(clk), .rst_n(rst_n), .src_en(src_en),
        .md_word(md_r), .ns_word(ns_r),
        .div_out(div_out), .running(running)
    );

    function automatic logic [31:0] mk_ns(input logic [7:0] nminv, input logic [1:0] mode,
                                          input logic [1:0] pre, input logic [2:0] sel);
        return {8'h00, nminv, 8'h00, 1'b0, mode, pre, sel};
    endfunction

    function automatic logic [31:0] mk_md(input logic [15:0] m, input logic [15:0] d);
        return {m, ~d};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic capture(input int n, output logic [15:0] seq);
        seq = '0;
        for (int i = 0; i < n; i++) begin
            #2;
            seq = {seq[14:0], div_out};
            @(negedge clk);
        end
    endtask

    task automatic start(input logic [31:0] md, input logic [31:0] ns_cfg);
        md_r = md;
        ns_r = ns_cfg | HOLD | ROOT | BR;
        repeat (3) @(negedge clk);
        ns_r = ns_cfg | ROOT | BR;
    endtask

    task automatic t_reset;
        #2;
        chk("R1 div_out", {15'b0, div_out}, 16'd0);
        chk("R1 running", {15'b0, running}, 16'd0);
    endtask

    task automatic t_dual;
        logic [15:0] s;
        src_en = 8'hFF;
        start(mk_md(1, 2), mk_ns(8'hFC, 2, 0, 0));
        capture(8, s);
        chk("R2 M1N4D2", s, 16'b11001100);
        start(mk_md(1, 2), mk_ns(8'h03 ^ 8'hFF, 2, 0, 0) | 32'hFF000000);
        capture(8, s);
        chk("R2 upper NS bits ignored", s, 16'b11001100);
    endtask

    task automatic t_fractional;
        logic [15:0] s;
        start(mk_md(3, 4), mk_ns(8'hFA, 2, 0, 0));
        capture(8, s);
        chk("R3 M3N8D4", s, 16'b11010010);
    endtask

    task automatic t_single;
        logic [15:0] s;
        start(mk_md(1, 2), mk_ns(8'hFC, 1, 0, 0));
        capture(8, s);
        chk("R4 mode1", s, 16'b10001000);
        start(mk_md(1, 2), mk_ns(8'hFC, 3, 0, 0));
        capture(8, s);
        chk("R4 mode3", s, 16'b10001000);
    endtask

    task automatic t_bypass;
        logic [15:0] s;
        start(mk_md(1, 2), mk_ns(8'hFC, 0, 1, 0));
        capture(8, s);
        chk("R5 mode0 bypass", s, 16'b00101010);
        start(mk_md(1, 2), mk_ns(8'h00, 2, 1, 0));
        capture(8, s);
        chk("R5 N=0 bypass", s, 16'b00101010);
    endtask

    task automatic t_prediv;
        logic [15:0] s;
        start(mk_md(1, 2), mk_ns(8'hFC, 2, 3, 0));
        capture(16, s);
        chk("R6 prediv4", s, 16'b1111111100000000);
    endtask

    task automatic t_select;
        logic [15:0] s;
        src_en = 8'b11111101;
        start(mk_md(1, 2), mk_ns(8'hFC, 2, 0, 1));
        capture(8, s);
        chk("R7 idle source frozen", s, 16'b11111111);
        src_en = 8'b00100000;
        start(mk_md(1, 2), mk_ns(8'hFC, 2, 0, 5));
        capture(8, s);
        chk("R7 source 5", s, 16'b11001100);
        src_en = 8'hFF;
    endtask

    task automatic t_hold;
        logic [15:0] s;
        md_r = mk_md(1, 2);
        ns_r = mk_ns(8'hFC, 2, 0, 0) | HOLD | ROOT | BR;
        repeat (3) @(negedge clk);
        capture(3, s);
        chk("R8 held low", s, 16'b000);
        ns_r = mk_ns(8'hFC, 2, 0, 0) | ROOT | BR;
        capture(3, s);
        ns_r = ns_r | HOLD;
        #2;
        chk("R8 hold same cycle", {15'b0, div_out}, 16'd0);
        @(negedge clk);
        ns_r = mk_ns(8'hFC, 2, 0, 0) | ROOT | BR;
        capture(4, s);
        chk("R8 restart", s, 16'b1100);
    endtask

    task automatic t_root;
        logic [15:0] s;
        start(mk_md(1, 2), mk_ns(8'hFC, 2, 0, 0));
        capture(2, s);
        ns_r = mk_ns(8'hFC, 2, 0, 0) | BR;
        @(negedge clk);
        #2;
        chk("R9 running off", {15'b0, running}, 16'd0);
        @(negedge clk);
        capture(4, s);
        chk("R9 out low", s, 16'b0000);
    endtask

    task automatic t_branch;
        md_r = mk_md(1, 2);
        ns_r = mk_ns(8'hFC, 2, 0, 0);
        repeat (3) @(negedge clk);
        ns_r = mk_ns(8'hFC, 2, 0, 0) | ROOT | BR;
        #2;
        chk("R10 before edge", {15'b0, running}, 16'd0);
        @(negedge clk);
        #2;
        chk("R10 after one edge", {15'b0, running}, 16'd0);
        @(negedge clk);
        #2;
        chk("R10 after two edges", {15'b0, running}, 16'd1);
        @(negedge clk);
        ns_r = mk_ns(8'hFC, 2, 0, 0) | BR;
        repeat (4) @(negedge clk);
        #2;
        chk("R10 branch without root", {14'b0, running, div_out}, 16'd0);
        @(negedge clk);
    endtask

    task automatic t_boundary;
        logic [15:0] s;
        start(mk_md(1, 2), mk_ns(8'hFC, 2, 0, 0));
        s = '0;
        for (int i = 0; i < 8; i++) begin
            #2;
            s = {s[14:0], div_out};
            @(negedge clk);
            if (i == 1) md_r = mk_md(1, 3);
        end
        chk("R11 duty change at boundary", s, 16'b11001110);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        @(negedge clk);
        t_dual();
        t_fractional();
        t_single();
        t_bypass();
        t_prediv();
        t_select();
        t_hold();
        t_root();
        t_branch();
        t_boundary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule